// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block sits on the device side of a sectored flash memory and decides what a read returns while an embedded program or erase is in flight. When no operation is pending, it tells the data path to drive array contents. Once a program or erase starts, it produces a status byte instead. It takes start events from the command decoder, a completion and a pulse-limit indication from the embedded algorithm, suspend and resume requests, the per-sector protect bits and the read strobe with its address.

Two toggle bits give complementary information. Bit 6 inverts on every read while the device is actively working. Bit 2 inverts only on reads that fall in a sector marked for erasure, and it does so whether that erase is running or suspended. Bit 5 reports a failed operation and holds until a reset command. Requests aimed only at protected sectors are not run. Instead, bit 6 toggles for a fixed number of cycles and the block then returns to array data.

Top module: `flash_wstatus_gen`

## Requirements
- R1: After reset, and whenever no operation is pending, `array_sel_o` is 1 and `status_o` is 0x00. In status mode, bits 7, 4, 3, 1 and 0 of `status_o` are always 0.
- R2: A program start to an unprotected sector clears both toggle bits and enters status mode. Each read then inverts bit 6, so the first read shows 0x40. `op_done` returns the block to array data.
- R3: An erase start clears both toggle bits. While erasing, every read inverts bit 6. Only reads whose sector index, `rd_addr[ADDR_W-1:ADDR_W-log2(NUM_SECT)]`, is marked for erase also invert bit 2.
- R4: An erase marks only the selected sectors whose protect bit is 0. Reads to selected but protected sectors leave bit 2 unchanged.
- R5: In erase suspend, bit 6 holds. Reads to marked sectors still invert bit 2 and return status. Reads to unmarked sectors return array data. A resume restores toggling of bit 6.
- R6: A program started during erase suspend inverts bit 6 on every read and holds bit 2. All reads return status. `op_done` goes back to erase suspend.
- R7: An erase whose selected sectors are all protected toggles bit 6 on reads for exactly `ERS_REJ_CYC` cycles, counted from the clock edge that accepts the start. After that, reads return array data.
- R8: A program to a protected sector behaves the same way for exactly `PGM_REJ_CYC` cycles.
- R9: `pulse_limit_hit` during a running operation sets bit 5. Bit 5 stays set on every later read, and bit 6 keeps inverting on each read.
- R10: `reset_cmd` in the failed state returns the block to array data on the next cycle. `reset_cmd` while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One read cycle |
| rd_addr | input | ADDR_W | Read address |
| pgm_start | input | 1 | Program operation start event |
| pgm_addr | input | ADDR_W | Target address of the program |
| erase_start | input | 1 | Erase operation start event |
| erase_sel | input | NUM_SECT | Sectors selected by the erase |
| op_done | input | 1 | Embedded algorithm completed |
| susp_req | input | 1 | Suspend a running erase |
| resume_req | input | 1 | Resume a suspended erase |
| sect_prot | input | NUM_SECT | Protect bit per sector |
| pulse_limit_hit | input | 1 | Internal pulse-count limit exceeded |
| reset_cmd | input | 1 | Reset command from the decoder |
| status_o | output | 8 | Status byte for the current read |
| array_sel_o | output | 1 | 1: drive array data instead of status |

## Verification
The hardest state to reach is a program nested inside an erase suspend. In that state, bit 6 must toggle while the bit 2 value left over from the suspended erase stays frozen. The stimulus starts an erase that is half protected, suspends it, and probes both marked and unmarked sectors. It then launches a program inside the suspend and reads the marked sector again, both during that program and after it completes. The rejection windows are checked with one read on the last busy cycle and one on the first array cycle.

// File: rtl/fws_pkg.sv
package fws_pkg;
    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_PGM,
        ST_ERASE,
        ST_SUSP,
        ST_SUSP_PGM,
        ST_REJECT,
        ST_FAIL
    } fws_state_e;

    localparam int unsigned BIT_T6   = 6;
    localparam int unsigned BIT_FAIL = 5;
    localparam int unsigned BIT_T2   = 2;
endpackage

// File: rtl/fws_sector_decode.sv
module fws_sector_decode #(
    parameter int unsigned NUM_SECT = 8,
    localparam int unsigned SECT_W  = $clog2(NUM_SECT)
) (
    input  logic [SECT_W-1:0]   idx_i,
    output logic [NUM_SECT-1:0] hit_o
);
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_hit
        assign hit_o[g] = (idx_i == SECT_W'(g));
    end
endmodule

// File: rtl/fws_hold_timer.sv
module fws_hold_timer #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expired_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (run_i && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired_o = run_i && (tmr_q.cnt == '0);

    // R7
    timer_no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i != '0) |=> !expired_o);
endmodule

// File: rtl/fws_toggle_pair.sv
module fws_toggle_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inv6_i,
    input  logic inv2_i,
    output logic t6_o,
    output logic t2_o
);
    typedef struct packed {
        logic t6;
        logic t2;
    } tog_t;

    tog_t tog_d, tog_q;

    always_comb begin
        tog_d = tog_q;
        if (clr_i) begin
            tog_d = '0;
        end else begin
            if (inv6_i) tog_d.t6 = ~tog_q.t6;
            if (inv2_i) tog_d.t2 = ~tog_q.t2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tog_q <= '0;
        else        tog_q <= tog_d;
    end

    assign t6_o = tog_q.t6;
    assign t2_o = tog_q.t2;

    // R2
    t6_flips_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv6_i && !clr_i) |=> (t6_o != $past(t6_o)));

    // R5
    t6_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inv6_i && !clr_i) |=> $stable(t6_o));
endmodule

// File: rtl/flash_wstatus_gen.sv
module flash_wstatus_gen
    import fws_pkg::*;
#(
    parameter int unsigned ADDR_W      = 19,
    parameter int unsigned NUM_SECT    = 8,
    parameter int unsigned ERS_REJ_CYC = 2000,
    parameter int unsigned PGM_REJ_CYC = 400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                pgm_start,
    input  logic [ADDR_W-1:0]   pgm_addr,
    input  logic                erase_start,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic                op_done,
    input  logic                susp_req,
    input  logic                resume_req,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                pulse_limit_hit,
    input  logic                reset_cmd,
    output logic [7:0]          status_o,
    output logic                array_sel_o
);
    localparam int unsigned SECT_W = $clog2(NUM_SECT);
    localparam int unsigned MAX_CYC = (ERS_REJ_CYC > PGM_REJ_CYC) ? ERS_REJ_CYC : PGM_REJ_CYC;
    localparam int unsigned CNT_W  = $clog2(MAX_CYC + 1);

    typedef struct packed {
        fws_state_e          st;
        logic [NUM_SECT-1:0] mark;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_SECT-1:0] rd_hit, pgm_hit, eff_sel;
    logic                rd_marked, pgm_prot;
    logic                tmr_load, tmr_run, tmr_expired;
    logic [CNT_W-1:0]    tmr_val;
    logic                tog_clr, inv6, inv2, t6, t2;

    fws_sector_decode #(.NUM_SECT(NUM_SECT)) u_rd_dec (
        .idx_i (rd_addr[ADDR_W-1 -: SECT_W]),
        .hit_o (rd_hit)
    );

    fws_sector_decode #(.NUM_SECT(NUM_SECT)) u_pgm_dec (
        .idx_i (pgm_addr[ADDR_W-1 -: SECT_W]),
        .hit_o (pgm_hit)
    );

    assign rd_marked = |(rd_hit & ctl_q.mark);
    assign pgm_prot  = |(pgm_hit & sect_prot);
    assign eff_sel   = erase_sel & ~sect_prot;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tog_clr  = 1'b0;
        unique case (ctl_q.st)
            ST_ARRAY: begin
                if (pgm_start) begin
                    tog_clr    = 1'b1;
                    ctl_d.mark = '0;
                    if (pgm_prot) begin
                        ctl_d.st = ST_REJECT;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PGM_REJ_CYC - 1);
                    end else begin
                        ctl_d.st = ST_PGM;
                    end
                end else if (erase_start && (|erase_sel)) begin
                    tog_clr = 1'b1;
                    if (|eff_sel) begin
                        ctl_d.st   = ST_ERASE;
                        ctl_d.mark = eff_sel;
                    end else begin
                        ctl_d.st   = ST_REJECT;
                        ctl_d.mark = '0;
                        tmr_load   = 1'b1;
                        tmr_val    = CNT_W'(ERS_REJ_CYC - 1);
                    end
                end
            end
            ST_PGM: begin
                if (pulse_limit_hit)  ctl_d.st = ST_FAIL;
                else if (op_done)     ctl_d.st = ST_ARRAY;
            end
            ST_ERASE: begin
                if (pulse_limit_hit) begin
                    ctl_d.st = ST_FAIL;
                end else if (op_done) begin
                    ctl_d.st   = ST_ARRAY;
                    ctl_d.mark = '0;
                end else if (susp_req) begin
                    ctl_d.st = ST_SUSP;
                end
            end
            ST_SUSP: begin
                if (resume_req)                   ctl_d.st = ST_ERASE;
                else if (pgm_start && !pgm_prot)  ctl_d.st = ST_SUSP_PGM;
            end
            ST_SUSP_PGM: begin
                if (pulse_limit_hit)  ctl_d.st = ST_FAIL;
                else if (op_done)     ctl_d.st = ST_SUSP;
            end
            ST_REJECT: begin
                if (tmr_expired) ctl_d.st = ST_ARRAY;
            end
            ST_FAIL: begin
                if (reset_cmd) begin
                    ctl_d.st   = ST_ARRAY;
                    ctl_d.mark = '0;
                end
            end
            default: begin
                ctl_d.st   = ST_ARRAY;
                ctl_d.mark = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_ARRAY;
            ctl_q.mark <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tmr_run = (ctl_q.st == ST_REJECT);

    fws_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .run_i      (tmr_run),
        .expired_o  (tmr_expired)
    );

    always_comb begin
        inv6 = 1'b0;
        inv2 = 1'b0;
        if (rd_stb) begin
            unique case (ctl_q.st)
                ST_PGM, ST_SUSP_PGM, ST_REJECT: inv6 = 1'b1;
                ST_ERASE, ST_FAIL: begin
                    inv6 = 1'b1;
                    inv2 = rd_marked;
                end
                ST_SUSP:  inv2 = rd_marked;
                default: ;
            endcase
        end
    end

    fws_toggle_pair u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tog_clr),
        .inv6_i (inv6),
        .inv2_i (inv2),
        .t6_o   (t6),
        .t2_o   (t2)
    );

    always_comb begin
        array_sel_o = (ctl_q.st == ST_ARRAY) || (ctl_q.st == ST_SUSP && !rd_marked);
        status_o    = '0;
        if (!array_sel_o) begin
            status_o[BIT_T6]   = t6;
            status_o[BIT_FAIL] = (ctl_q.st == ST_FAIL);
            status_o[BIT_T2]   = t2;
        end
    end

    // R9
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[BIT_FAIL] && !reset_cmd) |=> status_o[BIT_FAIL]);

    // R10
    reset_cmd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_FAIL && reset_cmd) |=> array_sel_o);

    // R5
    susp_t6_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_SUSP && rd_stb && !resume_req && !pgm_start) |=> $stable(t6));

    // R4
    mark_excludes_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ARRAY && erase_start && !pgm_start) |=> ((ctl_q.mark & $past(sect_prot)) == '0));
endmodule

// File: tb/flash_wstatus_gen_tb.sv
`timescale 1ns/1ps
module flash_wstatus_gen_tb;
    localparam int unsigned AW  = 19;
    localparam int unsigned NS  = 8;
    localparam int unsigned ERS = 60;
    localparam int unsigned PGM = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          pgm_start = 1'b0;
    logic [AW-1:0] pgm_addr = '0;
    logic          erase_start = 1'b0;
    logic [NS-1:0] erase_sel = '0;
    logic          op_done = 1'b0;
    logic          susp_req = 1'b0;
    logic          resume_req = 1'b0;
    logic [NS-1:0] sect_prot = '0;
    logic          pulse_limit_hit = 1'b0;
    logic          reset_cmd = 1'b0;
    logic [7:0]    status_o;
    logic          array_sel_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] st;
        logic       arr;
        string      req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    flash_wstatus_gen #(
        .ADDR_W(AW), .NUM_SECT(NS), .ERS_REJ_CYC(ERS), .PGM_REJ_CYC(PGM)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .pgm_start(pgm_start), .pgm_addr(pgm_addr), .erase_start(erase_start),
        .erase_sel(erase_sel), .op_done(op_done), .susp_req(susp_req),
        .resume_req(resume_req), .sect_prot(sect_prot),
        .pulse_limit_hit(pulse_limit_hit), .reset_cmd(reset_cmd),
        .status_o(status_o), .array_sel_o(array_sel_o)
    );

    function automatic logic [AW-1:0] sa(input int s);
        return AW'(s) << (AW - 3);
    endfunction

    task automatic compare(input logic [7:0] st, input logic arr, input string req);
        n_chk++;
        if (status_o !== st || array_sel_o !== arr) begin
            n_fail++;
            $display("FAIL %s: status=%02h arr=%0b expected status=%02h arr=%0b",
                     req, status_o, array_sel_o, st, arr);
        end
    endtask

    // driver: one read per call, expected result goes to the scoreboard
    task automatic rd(input int s, input logic [7:0] st, input logic arr, input string req);
        exp_t e;
        e.st = st; e.arr = arr; e.req = req;
        sb_q.push_back(e);
        rd_stb  = 1'b1;
        rd_addr = sa(s) + AW'(3);
        @(negedge clk);
        rd_stb  = 1'b0;
    endtask

    // monitor: the result of a read is visible after the edge that took it
    always @(posedge clk) begin
        if (rd_stb) begin
            #1;
            if (sb_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                compare(e.st, e.arr, e.req);
            end
        end
    end

    task automatic ev_pgm(input int s);
        pgm_addr = sa(s); pgm_start = 1'b1; @(negedge clk); pgm_start = 1'b0;
    endtask
    task automatic ev_erase(input logic [NS-1:0] sel);
        erase_sel = sel; erase_start = 1'b1; @(negedge clk); erase_start = 1'b0;
    endtask
    task automatic ev_done;   op_done = 1'b1;         @(negedge clk); op_done = 1'b0;         endtask
    task automatic ev_susp;   susp_req = 1'b1;        @(negedge clk); susp_req = 1'b0;        endtask
    task automatic ev_resume; resume_req = 1'b1;      @(negedge clk); resume_req = 1'b0;      endtask
    task automatic ev_limit;  pulse_limit_hit = 1'b1; @(negedge clk); pulse_limit_hit = 1'b0; endtask
    task automatic ev_rstcmd; reset_cmd = 1'b1;       @(negedge clk); reset_cmd = 1'b0;       endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(8'h00, 1'b1, "R1 reset state");
        rd(0, 8'h00, 1'b1, "R1 idle read");

        // R2 program, with R10 ignored reset command
        ev_pgm(1);
        rd(0, 8'h40, 1'b0, "R2 first read");
        rd(5, 8'h00, 1'b0, "R2 second read");
        ev_rstcmd();
        rd(1, 8'h40, 1'b0, "R10 reset ignored while running");
        ev_done();
        rd(1, 8'h00, 1'b1, "R2 back to array");

        // R3/R4 erase of sectors 2 and 3 with sector 3 protected
        sect_prot = 8'h08;
        ev_erase(8'h0C);
        rd(2, 8'h44, 1'b0, "R3 marked read");
        rd(3, 8'h04, 1'b0, "R4 protected sector not marked");
        rd(0, 8'h44, 1'b0, "R3 unmarked read");
        rd(2, 8'h00, 1'b0, "R3 marked read again");
        // R5 suspend
        ev_susp();
        rd(2, 8'h04, 1'b0, "R5 suspend marked read");
        rd(5, 8'h00, 1'b1, "R5 suspend unmarked read gives array");
        rd(2, 8'h00, 1'b0, "R5 bit6 held");
        // R6 program inside suspend
        ev_pgm(6);
        rd(6, 8'h40, 1'b0, "R6 program in suspend");
        rd(2, 8'h00, 1'b0, "R6 bit2 held");
        rd(2, 8'h40, 1'b0, "R6 bit6 toggles");
        ev_done();
        rd(2, 8'h44, 1'b0, "R6 back to suspend");
        ev_resume();
        rd(2, 8'h00, 1'b0, "R5 resumed toggling");
        rd(7, 8'h40, 1'b0, "R3 unmarked after resume");
        ev_done();
        rd(2, 8'h00, 1'b1, "R3 erase complete");

        // R7 erase of protected sector only
        ev_erase(8'h08);
        rd(3, 8'h40, 1'b0, "R7 rejected erase toggles");
        rd(3, 8'h00, 1'b0, "R7 rejected erase bit2 quiet");
        repeat (ERS - 4) @(negedge clk);
        rd(3, 8'h40, 1'b0, "R7 last busy cycle");
        rd(3, 8'h00, 1'b1, "R7 first array cycle");

        // R8 program to protected sector
        ev_pgm(3);
        rd(0, 8'h40, 1'b0, "R8 rejected program toggles");
        rd(0, 8'h00, 1'b0, "R8 second read");
        repeat (PGM - 4) @(negedge clk);
        rd(0, 8'h40, 1'b0, "R8 last busy cycle");
        rd(0, 8'h00, 1'b1, "R8 first array cycle");

        // R9/R10 program failure
        ev_pgm(1);
        ev_limit();
        rd(1, 8'h60, 1'b0, "R9 fail bit set");
        rd(1, 8'h20, 1'b0, "R9 fail bit sticks");
        ev_rstcmd();
        rd(1, 8'h00, 1'b1, "R10 reset from fail");

        // R9 erase failure
        ev_erase(8'h10);
        rd(4, 8'h44, 1'b0, "R3 erase sector 4");
        ev_limit();
        rd(4, 8'h20, 1'b0, "R9 erase fail");
        rd(4, 8'h64, 1'b0, "R9 erase fail toggles");
        ev_rstcmd();
        rd(4, 8'h00, 1'b1, "R10 reset from erase fail");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items left expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule